// File: doc/BRIEF.md
# Custom Instruction Match and Redirect

This block is the decode side of a custom-instruction extension for a small in-order pipeline. Every fetched 32-bit word is compared with one pattern per extension. A pattern is a value plus a care mask, so any bit can be left as don't-care. The result is a one-hot match vector, where the lowest-indexed extension wins when several patterns hit. There is also an any-match flag and a signal that masks the core's illegal-instruction trap.

When stage 0 accepts a word, the winning extension bit is latched. That bit then travels down a configurable number of stages together with the instruction. It holds while the stage is stalled and is cleared when the stage is flushed. Each stage exposes one presence bit per extension, and every consumer of that stage sees the same bit.

Extensions may request a next-PC redirect in any stage. The block selects, per stage, the request of the extension that owns the instruction held there. An accepted redirect raises the flush of every earlier stage without help from the extension. Ownership comes only from registered state. As a result, no input word or fetch-side value reaches the redirect selection combinationally.

Top module: `cim_decode_top`

## Requirements
- R1: With the default patterns, extension 0 matches opcode bits [6:0]=0001011 with bits [14:12]=000, and extension 1 matches the same opcode with bits [14:12]=001. Extension 2 matches that opcode with every other bit don't-care. Bit e of `match_oh_o` can be set only when the word agrees with pattern e on every cared bit.
- R2: When several patterns hit, only the lowest-indexed one appears in `match_oh_o`. `any_match_o` is 1 exactly when at least one pattern hits.
- R3: `trap_suppress_o` is 1 exactly when `instr_valid_i` is 1 and some pattern hits.
- R4: At a clock edge where stage 0 is neither stalled nor flushed, stage 0 captures `match_oh_o` if `instr_valid_i` is 1, and otherwise captures zero.
- R5: A stage s>0 that is neither stalled nor flushed takes the presence bits of stage s-1 at the edge. If stage s-1 is stalled, it takes zero instead.
- R6: A stalled stage that is not flushed keeps its ownership bits across the edge.
- R7: The presence bits `present_o[s*NE +: NE]` of a flushed stage read 0 in that same cycle, and its ownership bits are cleared at the next edge.
- R8: `redir_pc_o` for a stage carries the PC value of the owning extension, or zero when the stage has no owner. `redir_vld_o` for that stage is 1 only when the owner's request bit is 1 and the stage is neither stalled nor flushed. Requests from extensions that do not own the stage are ignored.
- R9: `flush_o[s]` is the OR of `core_flush_i[s]` and every accepted redirect in a later stage. A redirect in a stage that is itself flushed is not accepted.
- R10: Holding `rst_n` low across a clock edge clears all ownership bits.
- R11: Redirect selection depends only on registered ownership. A change of `instr_i` or `instr_valid_i` cannot alter `redir_vld_o`, `redir_pc_o` or `flush_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Fetched instruction word |
| instr_valid_i | input | 1 | Fetched word is valid |
| stall_i | input | NS | Per-stage stall from the core |
| core_flush_i | input | NS | Per-stage flush from the core |
| ext_pc_i | input | NS*NE*PCW | Redirect PC, slot (s*NE+e) |
| ext_pc_vld_i | input | NS*NE | Redirect request, bit (s*NE+e) |
| match_oh_o | output | NE | One-hot winning extension for instr_i |
| any_match_o | output | 1 | Some pattern hits instr_i |
| trap_suppress_o | output | 1 | Mask the core's illegal-instruction trap |
| present_o | output | NS*NE | Per-stage, per-extension presence bits |
| flush_o | output | NS | Effective per-stage flush |
| redir_vld_o | output | NS | Accepted redirect per stage |
| redir_pc_o | output | NS*PCW | Selected redirect PC per stage |

## Verification
A redirect in a late stage can fall in the same cycle as a core flush, a stall or a fresh capture in an earlier stage. The bench provokes these overlaps in two ways. It parks an owned instruction in stage 2 under stall while requests from the owner and a non-owner are pending, and then releases the stall while new words enter stage 0. It also uses a long run with random stall depths, flushes and request bits. The bench model settles flushes from the last stage downward and predicts which of the colliding events wins. It compares presence, flush and redirect outputs every cycle.

// File: rtl/cim_pkg.sv
package cim_pkg;
  localparam int unsigned INSTR_W = 32;

  // A word hits a pattern when it agrees with the value on every cared bit.
  function automatic logic word_hits(input logic [INSTR_W-1:0] word,
                                     input logic [INSTR_W-1:0] val,
                                     input logic [INSTR_W-1:0] care);
    return ((word ^ val) & care) == '0;
  endfunction
endpackage

// File: rtl/cim_matcher.sv
module cim_matcher #(
  parameter int unsigned NE = 3,
  parameter logic [NE*cim_pkg::INSTR_W-1:0] PAT_VAL  = '0,
  parameter logic [NE*cim_pkg::INSTR_W-1:0] PAT_CARE = '0
) (
  input  logic [cim_pkg::INSTR_W-1:0] instr_i,
  output logic [NE-1:0]               match_oh_o,
  output logic                        any_o
);
  localparam int unsigned IW = cim_pkg::INSTR_W;

  logic [NE-1:0] raw_hit;

  for (genvar e = 0; e < NE; e++) begin : g_pat
    assign raw_hit[e] = cim_pkg::word_hits(instr_i, PAT_VAL[e*IW +: IW],
                                           PAT_CARE[e*IW +: IW]);
  end

  // Lowest index wins.
  always_comb begin
    logic taken;
    taken      = 1'b0;
    match_oh_o = '0;
    for (int e = 0; e < NE; e++) begin
      if (raw_hit[e] && !taken) begin
        match_oh_o[e] = 1'b1;
        taken         = 1'b1;
      end
    end
  end

  assign any_o = |raw_hit;
endmodule

// File: rtl/cim_stage_track.sv
module cim_stage_track #(
  parameter int unsigned NE = 3,
  parameter int unsigned NS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NE-1:0]    head_i,
  input  logic [NS-1:0]    stall_i,
  input  logic [NS-1:0]    flush_i,
  output logic [NS*NE-1:0] owner_o,
  output logic [NS*NE-1:0] present_o
);
  for (genvar s = 0; s < NS; s++) begin : g_stage
    logic [NE-1:0] own_q;
    logic [NE-1:0] feed;

    if (s == 0) begin : g_head
      assign feed = head_i;
    end else begin : g_body
      assign feed = stall_i[s-1] ? '0 : present_o[(s-1)*NE +: NE];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          own_q <= '0;
      else if (flush_i[s]) own_q <= '0;
      else if (!stall_i[s]) own_q <= feed;
    end

    assign owner_o[s*NE +: NE]   = own_q;
    assign present_o[s*NE +: NE] = own_q & {NE{~flush_i[s]}};
  end
endmodule

// File: rtl/cim_redirect.sv
module cim_redirect #(
  parameter int unsigned NE  = 3,
  parameter int unsigned NS  = 4,
  parameter int unsigned PCW = 32
) (
  input  logic [NS*NE-1:0]     owner_i,
  input  logic [NS-1:0]        stall_i,
  input  logic [NS-1:0]        core_flush_i,
  input  logic [NS*NE*PCW-1:0] ext_pc_i,
  input  logic [NS*NE-1:0]     ext_pc_vld_i,
  output logic [NS-1:0]        flush_o,
  output logic [NS-1:0]        redir_vld_o,
  output logic [NS*PCW-1:0]    redir_pc_o
);
  logic [NS-1:0] owned_req;

  for (genvar s = 0; s < NS; s++) begin : g_mux
    assign owned_req[s] = |(owner_i[s*NE +: NE] & ext_pc_vld_i[s*NE +: NE]);

    always_comb begin
      logic [PCW-1:0] acc;
      acc = '0;
      for (int e = 0; e < NE; e++) begin
        if (owner_i[s*NE + e]) acc = acc | ext_pc_i[(s*NE + e)*PCW +: PCW];
      end
      redir_pc_o[s*PCW +: PCW] = acc;
    end
  end

  // Settle from the last stage toward stage 0.
  always_comb begin
    logic kill;
    kill        = 1'b0;
    flush_o     = '0;
    redir_vld_o = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      flush_o[s]     = core_flush_i[s] | kill;
      redir_vld_o[s] = owned_req[s] & ~stall_i[s] & ~flush_o[s];
      kill           = kill | redir_vld_o[s];
    end
  end
endmodule

// File: rtl/cim_decode_top.sv
module cim_decode_top #(
  parameter int unsigned NE  = 3,
  parameter int unsigned NS  = 4,
  parameter int unsigned PCW = 32,
  parameter logic [NE*32-1:0] PAT_VAL  = {32'h0000_000B, 32'h0000_100B, 32'h0000_000B},
  parameter logic [NE*32-1:0] PAT_CARE = {32'h0000_007F, 32'h0000_707F, 32'h0000_707F}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          instr_i,
  input  logic                 instr_valid_i,
  input  logic [NS-1:0]        stall_i,
  input  logic [NS-1:0]        core_flush_i,
  input  logic [NS*NE*PCW-1:0] ext_pc_i,
  input  logic [NS*NE-1:0]     ext_pc_vld_i,
  output logic [NE-1:0]        match_oh_o,
  output logic                 any_match_o,
  output logic                 trap_suppress_o,
  output logic [NS*NE-1:0]     present_o,
  output logic [NS-1:0]        flush_o,
  output logic [NS-1:0]        redir_vld_o,
  output logic [NS*PCW-1:0]    redir_pc_o
);
  logic [NE-1:0]    head_bits;
  logic [NS*NE-1:0] owner_q;

  cim_matcher #(.NE(NE), .PAT_VAL(PAT_VAL), .PAT_CARE(PAT_CARE)) u_match (
    .instr_i    (instr_i),
    .match_oh_o (match_oh_o),
    .any_o      (any_match_o)
  );

  assign head_bits       = instr_valid_i ? match_oh_o : '0;
  assign trap_suppress_o = instr_valid_i & any_match_o;

  cim_stage_track #(.NE(NE), .NS(NS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_i    (head_bits),
    .stall_i   (stall_i),
    .flush_i   (flush_o),
    .owner_o   (owner_q),
    .present_o (present_o)
  );

  cim_redirect #(.NE(NE), .NS(NS), .PCW(PCW)) u_redir (
    .owner_i      (owner_q),
    .stall_i      (stall_i),
    .core_flush_i (core_flush_i),
    .ext_pc_i     (ext_pc_i),
    .ext_pc_vld_i (ext_pc_vld_i),
    .flush_o      (flush_o),
    .redir_vld_o  (redir_vld_o),
    .redir_pc_o   (redir_pc_o)
  );
endmodule

// File: rtl/cim_checker.sv
module cim_checker #(
  parameter int unsigned NE = 3,
  parameter int unsigned NS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid_i,
  input logic [NS-1:0]    stall_i,
  input logic [NE-1:0]    match_oh_o,
  input logic             any_match_o,
  input logic             trap_suppress_o,
  input logic [NS*NE-1:0] owner_q,
  input logic [NS*NE-1:0] present_o,
  input logic [NS-1:0]    flush_o,
  input logic [NS-1:0]    redir_vld_o
);
  // R2
  match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_oh_o));

  // R2
  any_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_match_o == (match_oh_o != '0));

  // R3
  suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_suppress_o |-> (any_match_o && instr_valid_i));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (owner_q == '0));

  for (genvar s = 0; s < NS; s++) begin : g_chk
    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o[s] |-> (present_o[s*NE +: NE] == '0));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i[s] && !flush_o[s]) |=> $stable(owner_q[s*NE +: NE]));

    // R8
    redirect_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld_o[s] |-> (owner_q[s*NE +: NE] != '0 && !stall_i[s]));

    // R2
    owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner_q[s*NE +: NE]));

    if (s > 0) begin : g_up
      // R9
      redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld_o[s] |-> flush_o[s-1]);

      // R5
      advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i[s] && !stall_i[s-1] && !flush_o[s])
          |=> (owner_q[s*NE +: NE] == $past(present_o[(s-1)*NE +: NE])));
    end
  end
endmodule

bind cim_decode_top cim_checker #(.NE(NE), .NS(NS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .instr_valid_i   (instr_valid_i),
  .stall_i         (stall_i),
  .match_oh_o      (match_oh_o),
  .any_match_o     (any_match_o),
  .trap_suppress_o (trap_suppress_o),
  .owner_q         (owner_q),
  .present_o       (present_o),
  .flush_o         (flush_o),
  .redir_vld_o     (redir_vld_o)
);

// File: tb/tb_cim_decode_top.sv
module tb_cim_decode_top;
  localparam int NE = 3;
  localparam int NS = 4;
  localparam int PCW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n;
  logic [31:0]          instr_i;
  logic                 instr_valid_i;
  logic [NS-1:0]        stall_i;
  logic [NS-1:0]        core_flush_i;
  logic [NS*NE*PCW-1:0] ext_pc_i;
  logic [NS*NE-1:0]     ext_pc_vld_i;
  logic [NE-1:0]        match_oh_o;
  logic                 any_match_o;
  logic                 trap_suppress_o;
  logic [NS*NE-1:0]     present_o;
  logic [NS-1:0]        flush_o;
  logic [NS-1:0]        redir_vld_o;
  logic [NS*PCW-1:0]    redir_pc_o;

  cim_decode_top dut (.*);

  // Patterns as text, leftmost character is bit 31; '-' is don't-care.
  string pat [NE];
  initial begin
    pat[0] = "-----------------000-----0001011";
    pat[1] = "-----------------001-----0001011";
    pat[2] = "-------------------------0001011";
  end

  function automatic bit pat_hit(int e, logic [31:0] w);
    for (int i = 0; i < 32; i++) begin
      if (pat[e][i] == "1" && w[31-i] !== 1'b1) return 1'b0;
      if (pat[e][i] == "0" && w[31-i] !== 1'b0) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [PCW-1:0] pc_of(int s, int e);
    return 32'h4000_0000 + 32'(s) * 32'h100 + 32'(e) * 32'h10;
  endfunction

  typedef struct {
    logic [NE-1:0]     moh;
    logic              any;
    logic              sup;
    logic [NS*NE-1:0]  pres;
    logic [NS-1:0]     fl;
    logic [NS-1:0]     rv;
    logic [NS*PCW-1:0] rpc;
    string             tag;
  } exp_t;

  exp_t q [$];
  int own [NS];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(string what, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Monitor: pops each expectation and compares it with the outputs.
  always begin
    exp_t x;
    wait (q.size() != 0);
    x = q.pop_front();
    chk({x.tag, " match_oh (R1 R2)"}, 512'(match_oh_o), 512'(x.moh));
    chk({x.tag, " any_match (R2)"}, 512'(any_match_o), 512'(x.any));
    chk({x.tag, " trap_suppress (R3)"}, 512'(trap_suppress_o), 512'(x.sup));
    chk({x.tag, " present"}, 512'(present_o), 512'(x.pres));
    chk({x.tag, " flush (R9)"}, 512'(flush_o), 512'(x.fl));
    chk({x.tag, " redir_vld (R8)"}, 512'(redir_vld_o), 512'(x.rv));
    chk({x.tag, " redir_pc (R8)"}, 512'(redir_pc_o), 512'(x.rpc));
  end

  // Driver: applies one cycle, predicts outputs, then advances the model.
  task automatic step(logic r, logic [31:0] w, logic v, logic [NS-1:0] st,
                      logic [NS-1:0] cf, logic [NS*NE-1:0] pv, string tag);
    exp_t x;
    int win;
    bit kill;
    int nxt [NS];
    @(negedge clk);
    rst_n = r; instr_i = w; instr_valid_i = v;
    stall_i = st; core_flush_i = cf; ext_pc_vld_i = pv;
    #1;
    win = -1;
    x.any = 1'b0;
    for (int e = 0; e < NE; e++) begin
      if (pat_hit(e, w)) begin
        x.any = 1'b1;
        if (win < 0) win = e;
      end
    end
    x.moh = '0;
    if (win >= 0) x.moh[win] = 1'b1;
    x.sup = v & x.any;
    kill = 1'b0;
    for (int s = NS - 1; s >= 0; s--) begin
      x.fl[s] = cf[s] | kill;
      x.rv[s] = (own[s] >= 0) && pv[s*NE + own[s]] && !st[s] && !x.fl[s];
      if (x.rv[s]) kill = 1'b1;
    end
    x.pres = '0;
    x.rpc  = '0;
    for (int s = 0; s < NS; s++) begin
      if (own[s] >= 0 && !x.fl[s]) x.pres[s*NE + own[s]] = 1'b1;
      if (own[s] >= 0) x.rpc[s*PCW +: PCW] = pc_of(s, own[s]);
    end
    x.tag = tag;
    q.push_back(x);
    for (int s = 0; s < NS; s++) begin
      if (!r || x.fl[s])  nxt[s] = -1;
      else if (st[s])     nxt[s] = own[s];
      else if (s == 0)    nxt[s] = v ? win : -1;
      else if (st[s-1])   nxt[s] = -1;
      else                nxt[s] = x.fl[s-1] ? -1 : own[s-1];
    end
    @(posedge clk);
    for (int s = 0; s < NS; s++) own[s] = nxt[s];
  endtask

  localparam logic [31:0] W0  = 32'h0000_000B; // ext0 and ext2 hit
  localparam logic [31:0] W1  = 32'h0000_100B; // ext1 and ext2 hit
  localparam logic [31:0] W2  = 32'h0000_200B; // ext2 only
  localparam logic [31:0] WN  = 32'h0000_0033; // no hit
  localparam logic [31:0] W0X = 32'hFFFF_808B; // ext0 with don't-cares set
  localparam logic [NS-1:0] NOST = '0;
  localparam logic [NS*NE-1:0] NOPV = '0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [5];
    for (int s = 0; s < NS; s++) own[s] = -1;
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < NE; e++)
        ext_pc_i[(s*NE + e)*PCW +: PCW] = pc_of(s, e);
    rst_n = 1'b0; instr_i = '0; instr_valid_i = 1'b0;
    stall_i = '0; core_flush_i = '0; ext_pc_vld_i = '0;

    // R10: reset state
    step(1'b0, W0, 1'b1, NOST, '0, NOPV, "R10 reset");
    step(1'b0, W1, 1'b1, NOST, '0, NOPV, "R10 reset");

    // R1 R2 R4 R5: stream of distinct words
    step(1'b1, W0,  1'b1, NOST, '0, NOPV, "R1 R2 W0");
    step(1'b1, W1,  1'b1, NOST, '0, NOPV, "R1 R2 W1");
    step(1'b1, W2,  1'b1, NOST, '0, NOPV, "R1 W2");
    step(1'b1, WN,  1'b1, NOST, '0, NOPV, "R1 none");
    step(1'b1, W0X, 1'b1, NOST, '0, NOPV, "R1 dontcare");
    // R3 R4: invalid word is not captured and does not suppress the trap
    step(1'b1, W1,  1'b0, NOST, '0, NOPV, "R3 R4 invalid");
    step(1'b1, W2,  1'b1, NOST, '0, NOPV, "R5 advance");
    // R6: hold stages 0..2, then R5 bubble into stage 3 and stage 2
    step(1'b1, W0,  1'b1, 4'b0111, '0, NOPV, "R6 hold");
    step(1'b1, W1,  1'b1, 4'b0111, '0, NOPV, "R6 hold");
    step(1'b1, W1,  1'b1, 4'b0011, '0, NOPV, "R5 bubble");
    step(1'b1, W2,  1'b1, NOST, '0, NOPV, "R5 resume");
    // R7: core flush of stage 1, also under stall
    step(1'b1, W0,  1'b1, NOST, 4'b0010, NOPV, "R7 flush");
    step(1'b1, W0,  1'b1, 4'b0011, 4'b0001, NOPV, "R7 flush stalled");
    step(1'b1, WN,  1'b1, NOST, '0, NOPV, "R7 after");

    // R8 R9 R11: ext1 owns stage 2, requests from owner and non-owner
    step(1'b1, W1,  1'b1, NOST, '0, NOPV, "R8 load");
    step(1'b1, W0,  1'b1, NOST, '0, NOPV, "R8 load");
    step(1'b1, W2,  1'b1, NOST, '0, NOPV, "R8 load");
    step(1'b1, W0,  1'b1, 4'b0111, '0, 12'(1 << 6), "R8 non-owner ignored");
    step(1'b1, W1,  1'b0, 4'b0111, '0, 12'(1 << 6), "R8 non-owner ignored");
    step(1'b1, W2,  1'b1, 4'b0111, '0, 12'((1 << 7) | (1 << 6)), "R8 stalled");
    step(1'b1, W0X, 1'b1, NOST, '0, 12'((1 << 7) | (1 << 6)), "R9 R11 redirect");
    step(1'b1, WN,  1'b0, NOST, '0, NOPV, "R9 after");
    // R9: redirect in stage 3 while the core also flushes stage 3
    step(1'b1, W1,  1'b1, NOST, '0, NOPV, "R9 load");
    step(1'b1, W1,  1'b1, NOST, '0, NOPV, "R9 load");
    step(1'b1, W1,  1'b1, NOST, '0, NOPV, "R9 load");
    step(1'b1, W1,  1'b1, NOST, 4'b1000, 12'hFFF, "R9 flushed redirect");
    step(1'b1, W2,  1'b1, NOST, '0, 12'hFFF, "R9 multi redirect");

    // R10: reset in mid-run
    step(1'b0, W0,  1'b1, NOST, '0, NOPV, "R10 mid reset");
    step(1'b1, WN,  1'b0, NOST, '0, NOPV, "R10 after reset");

    // Mixed stimulus; stalls always cover a contiguous run from stage 0.
    pool[0] = W0; pool[1] = W1; pool[2] = W2; pool[3] = WN; pool[4] = W0X;
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [NS-1:0] st, cf;
      k  = $urandom_range(0, NS);
      st = NS'((1 << k) - 1);
      cf = ($urandom_range(0, 7) == 0) ? NS'(1 << $urandom_range(0, NS - 1)) : '0;
      step(1'b1, pool[$urandom_range(0, 4)], 1'($urandom_range(0, 1)), st, cf,
           12'($urandom), "mixed R4 R5 R6 R7 R8 R9");
    end

    @(negedge clk);
    wait (q.size() == 0);
    #1;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule